// File: doc/BRIEF.md
# Routing Table Lookup Engine

This block holds a routing table of destination addresses and answers "where does this packet go next" in a fixed three-cycle window. Each destination IPv4 address sits in a fully parallel content-addressable array. The forwarding data for each route is kept in a separate associated memory, and the index of the matching array entry is used as the address into it. That data is the next-hop address, the outgoing interface number and the hop count.

A controller starts a lookup by presenting a key for one cycle while the engine is idle. The key is compared against every valid entry in the first cycle, and the lowest matching index wins. The associated memory read takes the next two cycles. In the third cycle a one-cycle result strobe appears. On a hit, the forwarding fields and the matching index are driven. On a miss, the field drivers float and a destination-not-found flag is raised for the controller. A route is installed in three cycles. The first cycle writes the address into the match array, the second writes the next hop, and the third writes the interface and hop count.

Top module: `route_lookup`

## Requirements
- R1: After reset no table entry is valid, `busy` and `result_valid` are low, and any lookup before the first programming misses.
- R2: A lookup is accepted on a clock edge where `lookup_valid` is high, `busy` is low and `prog_valid` is low. `result_valid` is then high for exactly one cycle, which is the cycle after the second edge following acceptance (the third cycle of the lookup).
- R3: On a hit, `next_hop` (32 bits), `out_ifc` (8 bits) and `out_hops` (8 bits) carry the fields last programmed for the matching entry during the result cycle, and `match_index` carries that entry's index.
- R4: When several valid entries hold the searched key, the entry with the lowest index is reported.
- R5: On a miss, `not_found` is high during the result cycle and the three field outputs are high impedance.
- R6: `busy` is high for the two cycles that follow an accepted lookup or programming request, and it is low in the result cycle. Lookup and programming requests presented while `busy` is high are ignored.
- R7: A programming request is accepted on an edge where `prog_valid` is high and `busy` is low. It makes entry `prog_index` valid with key `prog_key` and the given fields, and it replaces whatever that entry held before. If a lookup is requested in the same cycle, programming takes precedence and the lookup is dropped.
- R8: `not_found` is never high outside a result cycle, and it is never high together with a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_valid | input | 1 | Lookup request strobe |
| lookup_key | input | 32 | Destination address to search |
| prog_valid | input | 1 | Route programming request strobe |
| prog_index | input | 8 | Table entry to program |
| prog_key | input | 32 | Destination address stored in the match array |
| prog_next_hop | input | 32 | Next-hop address for the entry |
| prog_ifc | input | 8 | Interface number for the entry |
| prog_hops | input | 8 | Hop count for the entry |
| busy | output | 1 | Engine occupied; new requests are ignored |
| result_valid | output | 1 | One-cycle lookup result strobe |
| not_found | output | 1 | Destination not found, valid with the result strobe |
| match_index | output | 8 | Index of the matching entry on a hit |
| next_hop | output | 32 | Next-hop address, high impedance when not driving a hit |
| out_ifc | output | 8 | Interface number, high impedance when not driving a hit |
| out_hops | output | 8 | Hop count, high impedance when not driving a hit |

## Verification
Lookups are issued against a randomly filled table with a mix of keys known to be present and keys known to be absent. This separates the hit data path from the not-found path. Duplicate keys placed at several indices show whether the reported entry is the lowest one, and entries at index 0 and at the last index check both ends of the encoder. Requests driven while the engine is busy, together with a lookup and a programming request raised in the same cycle, show whether a dropped request leaves any trace in later results. A rewritten entry shows whether the old fields are fully replaced.

// File: rtl/route_lookup.sv
module route_lookup #(
  parameter int KEY_W = 32,
  parameter int DEPTH = 256,
  parameter int HOP_W = 32,
  parameter int IFC_W = 8,
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lookup_valid,
  input  logic [KEY_W-1:0]         lookup_key,
  input  logic                     prog_valid,
  input  logic [$clog2(DEPTH)-1:0] prog_index,
  input  logic [KEY_W-1:0]         prog_key,
  input  logic [HOP_W-1:0]         prog_next_hop,
  input  logic [IFC_W-1:0]         prog_ifc,
  input  logic [CNT_W-1:0]         prog_hops,
  output logic                     busy,
  output logic                     result_valid,
  output logic                     not_found,
  output logic [$clog2(DEPTH)-1:0] match_index,
  output logic [HOP_W-1:0]         next_hop,
  output logic [IFC_W-1:0]         out_ifc,
  output logic [CNT_W-1:0]         out_hops
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [KEY_W-1:0] key_mem  [DEPTH];
  logic [DEPTH-1:0] key_vld;
  logic [HOP_W-1:0] nh_mem   [DEPTH];
  logic [IFC_W-1:0] ifc_mem  [DEPTH];
  logic [CNT_W-1:0] hops_mem [DEPTH];

  logic l1, l2, l3, p1, p2;
  logic hit1, hit2, hit3;
  logic [IDX_W-1:0] idx1, idx2, idx3;
  logic [HOP_W-1:0] rd_nh, res_nh;
  logic [IFC_W-1:0] rd_ifc, res_ifc;
  logic [CNT_W-1:0] rd_hops, res_hops;
  logic [IDX_W-1:0] pg_idx;
  logic [HOP_W-1:0] pg_nh;
  logic [IFC_W-1:0] pg_ifc;
  logic [CNT_W-1:0] pg_hops;

  logic hit_c;
  logic [IDX_W-1:0] idx_c;
  logic go_prog, go_look, drive;

  assign busy    = l1 | l2 | p1 | p2;
  assign go_prog = prog_valid & ~busy;
  assign go_look = lookup_valid & ~busy & ~prog_valid;

  always_comb begin
    hit_c = 1'b0;
    idx_c = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (key_vld[i] && key_mem[i] == lookup_key) begin
        hit_c = 1'b1;
        idx_c = i[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (go_prog) key_mem[prog_index] <= prog_key;
    if (p1) nh_mem[pg_idx] <= pg_nh;
    if (p2) begin
      ifc_mem[pg_idx]  <= pg_ifc;
      hops_mem[pg_idx] <= pg_hops;
    end
    if (go_prog) begin
      pg_idx  <= prog_index;
      pg_nh   <= prog_next_hop;
      pg_ifc  <= prog_ifc;
      pg_hops <= prog_hops;
    end
    if (go_look) idx1 <= idx_c;
    if (l1) begin
      rd_nh   <= nh_mem[idx1];
      rd_ifc  <= ifc_mem[idx1];
      rd_hops <= hops_mem[idx1];
      idx2    <= idx1;
    end
    if (l2) begin
      res_nh   <= rd_nh;
      res_ifc  <= rd_ifc;
      res_hops <= rd_hops;
      idx3     <= idx2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_vld <= '0;
      {l1, l2, l3, p1, p2} <= '0;
      {hit1, hit2, hit3}   <= '0;
    end else begin
      if (go_prog) key_vld[prog_index] <= 1'b1;
      l1 <= go_look;
      l2 <= l1;
      l3 <= l2;
      p1 <= go_prog;
      p2 <= p1;
      if (go_look) hit1 <= hit_c;
      if (l1) hit2 <= hit1;
      if (l2) hit3 <= hit2;
    end
  end

  assign result_valid = l3;
  assign not_found    = l3 & ~hit3;
  assign drive        = l3 & hit3;
  assign match_index  = drive ? idx3 : '0;
  assign next_hop     = drive ? res_nh   : 'z;
  assign out_ifc      = drive ? res_ifc  : 'z;
  assign out_hops     = drive ? res_hops : 'z;

  assert_result_third_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && !busy && !prog_valid) |-> ##3 result_valid);
  assert_result_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  assert_busy_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && !busy) |=> busy ##1 busy ##1 !busy);
  assert_notfound_in_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    not_found |-> result_valid);
  assert_one_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({l1, l2, l3, p1, p2}));
endmodule

// File: tb/sim_route_lookup.sv
module sim_route_lookup;
  logic clk = 0, rst_n = 0;
  logic lookup_valid = 0, prog_valid = 0;
  logic [31:0] lookup_key = 0, prog_key = 0, prog_next_hop = 0;
  logic [7:0] prog_index = 0, prog_ifc = 0, prog_hops = 0;
  logic busy, result_valid, not_found;
  logic [7:0] match_index, out_ifc, out_hops;
  logic [31:0] next_hop;

  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  route_lookup u0 (.clk, .rst_n, .lookup_valid, .lookup_key, .prog_valid, .prog_index,
    .prog_key, .prog_next_hop, .prog_ifc, .prog_hops, .busy, .result_valid, .not_found,
    .match_index, .next_hop, .out_ifc, .out_hops);

  logic [31:0] m_key [256];
  logic        m_vld [256];
  logic [31:0] m_nh  [256];
  logic [7:0]  m_ifc [256];
  logic [7:0]  m_hop [256];
  int mbusy = 0, rcnt = 0;
  logic e_hit; int e_idx;
  logic [31:0] e_nh; logic [7:0] e_ifc, e_hop;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_vld[i] = 0;
      mbusy = 0; rcnt = 0;
    end else begin
      automatic bit acc = (mbusy == 0);
      if (mbusy > 0) mbusy--;
      if (rcnt > 0) rcnt--;
      if (acc && prog_valid) begin
        m_key[prog_index] = prog_key; m_vld[prog_index] = 1;
        m_nh[prog_index] = prog_next_hop; m_ifc[prog_index] = prog_ifc;
        m_hop[prog_index] = prog_hops;
        mbusy = 2;
      end else if (acc && lookup_valid) begin
        e_hit = 0; e_idx = 0;
        for (int i = 255; i >= 0; i--)
          if (m_vld[i] && m_key[i] == lookup_key) begin e_hit = 1; e_idx = i; end
        mbusy = 2; rcnt = 3;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    automatic logic erv = (rcnt == 1);
    chk("R6 busy", {31'd0, busy}, {31'd0, mbusy > 0});
    chk("R2 result_valid", {31'd0, result_valid}, {31'd0, erv});
    chk("R5/R8 not_found", {31'd0, not_found}, {31'd0, erv && !e_hit});
    if (erv && e_hit) begin
      chk("R3 next_hop", next_hop, m_nh[e_idx]);
      chk("R3 ifc", {24'd0, out_ifc}, {24'd0, m_ifc[e_idx]});
      chk("R3 hops", {24'd0, out_hops}, {24'd0, m_hop[e_idx]});
      chk("R4 match_index", {24'd0, match_index}, e_idx);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic prog(int idx, logic [31:0] k, logic [31:0] nh, logic [7:0] f, logic [7:0] h);
    prog_valid = 1; prog_index = idx[7:0]; prog_key = k;
    prog_next_hop = nh; prog_ifc = f; prog_hops = h;
    @(negedge clk); prog_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic look(logic [31:0] k);
    lookup_valid = 1; lookup_key = k;
    @(negedge clk); lookup_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy after reset", {31'd0, busy}, 0);
    chk("R1 result_valid after reset", {31'd0, result_valid}, 0);
    look(32'h0);  // R1: empty table misses
    // R3 hit at both ends of the table
    prog(0, 32'h0A000001, 32'hC0A80001, 8'd3, 8'd1);
    prog(255, 32'h0A0000FF, 32'hC0A800FF, 8'd7, 8'd255);
    look(32'h0A000001);
    look(32'h0A0000FF);
    look(32'h0B000000);  // R5 miss
    // R4 duplicates: lowest index wins
    prog(90, 32'h12345678, 32'h11111111, 8'd9, 8'd4);
    prog(40, 32'h12345678, 32'h22222222, 8'd8, 8'd5);
    prog(200, 32'h12345678, 32'h33333333, 8'd7, 8'd6);
    look(32'h12345678);
    // R7 overwrite
    prog(40, 32'h87654321, 32'h44444444, 8'd1, 8'd2);
    look(32'h12345678);
    look(32'h87654321);
    // R6 lookup while busy ignored
    lookup_valid = 1; lookup_key = 32'h0A000001;
    @(negedge clk); lookup_key = 32'h87654321;
    @(negedge clk); lookup_valid = 0;
    repeat (3) @(negedge clk);
    // R6 programming while busy ignored
    lookup_valid = 1; lookup_key = 32'h0A0000FF;
    @(negedge clk); lookup_valid = 0;
    prog_valid = 1; prog_index = 8'd10; prog_key = 32'hDEADBEEF;
    @(negedge clk); prog_valid = 0;
    repeat (3) @(negedge clk);
    look(32'hDEADBEEF);
    // R7 programming beats a simultaneous lookup
    lookup_valid = 1; lookup_key = 32'h0A000001;
    prog_valid = 1; prog_index = 8'd11; prog_key = 32'hFEEDF00D;
    prog_next_hop = 32'h55555555; prog_ifc = 8'd2; prog_hops = 8'd3;
    @(negedge clk); lookup_valid = 0; prog_valid = 0;
    repeat (4) @(negedge clk);
    look(32'hFEEDF00D);
    // mixed random traffic
    for (int n = 0; n < 60; n++)
      prog($urandom_range(0, 255), {24'hAC1000, 8'($urandom_range(0, 63))},
           $urandom, 8'($urandom), 8'($urandom));
    for (int n = 0; n < 300; n++)
      look({24'hAC1000, 8'($urandom_range(0, 127))});
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule